// File: doc/BRIEF.md
# Register Rename Map with Undo History

This block renames the architectural registers of a small single-thread out-of-order core onto a larger pool of physical registers. A table holds the current physical register of each architectural register, and a FIFO holds the unallocated physical registers. A one-bit-per-register scoreboard records whether each physical register holds its value yet. Source lookup lanes return the mapped physical register together with its ready bit. One destination is renamed per cycle. Each rename takes the physical register at the head of the free FIFO, marks it not ready, and records the mapping it replaced in a circular history buffer. Every history record carries the instruction's sequence number.

Recovery does not use checkpoints. A squash walks the history from its youngest record towards its oldest, one record per cycle. For each record it restores the replaced mapping and hands the speculative register back to the free FIFO. A commit walks the history from the oldest record, one record per cycle, and releases each replaced register, which no longer has any reader. Architectural register 0 is a constant zero. It is always held on physical register 0, and renaming it allocates nothing. Its history records therefore have equal new and previous registers, and neither walk frees anything for them.

Top module: `rename_map_hist`

## Requirements
- R1: After reset, architectural register i maps to physical register i with ready = 1. The free FIFO holds physical registers ARCH_REGS to PHYS_REGS-1 and hands them out in ascending order.
- R2: A rename of a nonzero register has the following visible effects:
  - In the same cycle, `ren_phys` shows the head of the free FIFO and `ren_prev` shows the current mapping.
  - From the next cycle, a lookup of that register returns `ren_phys` with ready = 0.
- R3: A pulse on `wb_valid` sets the ready bit of `wb_phys`. Lookups show ready = 1 from the next cycle on.
- R4: `ren_ready` is 0 in two cases:
  - when the history buffer holds HIST_DEPTH records;
  - when a nonzero destination is presented and the free FIFO is empty.
- R5: A squash removes, youngest first, every record whose sequence number is greater than `sq_seq`. Each removed record restores its architectural register to the previous physical register and pushes the new physical register onto the tail of the free FIFO.
- R6: A commit removes, oldest first, every record whose sequence number is less than or equal to `cmt_seq`, and pushes each record's previous physical register onto the tail of the free FIFO. Records with larger sequence numbers stay.
- R7: A record whose new and previous physical registers are equal frees no register and changes no mapping when it is committed or squashed.
- R8: Architectural register 0 always looks up as physical register 0 with ready = 1. Renaming it is accepted even when the free FIFO is empty. It returns 0 on both `ren_phys` and `ren_prev`, consumes no free register, and still takes one history record.
- R9: Squash and commit take priority over rename. `ren_ready` is 0 in the cycle of a squash or commit request and while either walk is in progress. A commit walk pauses while a squash walk runs. The history changes by at most one record per cycle.
- R10: Sequence numbers are compared as unsigned values without wrap-around. A record equal to the squash number is kept, and a record equal to the commit number is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_arch | input | NUM_SRC*AW | Architectural source registers, lane k in bits [k*AW +: AW] |
| src_phys | output | NUM_SRC*PW | Mapped physical register per lane |
| src_rdy | output | NUM_SRC | Ready bit of each looked-up physical register |
| ren_valid | input | 1 | Rename request for one destination |
| ren_arch | input | AW | Architectural destination register |
| ren_seq | input | SEQ_W | Sequence number of the renaming instruction |
| ren_ready | output | 1 | Rename accepted this cycle when high with ren_valid |
| ren_phys | output | PW | Newly assigned physical register |
| ren_prev | output | PW | Physical register previously mapped to ren_arch |
| wb_valid | input | 1 | Result written, mark a physical register ready |
| wb_phys | input | PW | Physical register that became ready |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash all records younger than this number |

## Verification
The bound checker watches every cycle for the following:
- rename is blocked during any squash or commit request or walk;
- the history changes by no more than one record per cycle;
- neither occupancy count exceeds its capacity;
- register 0 looks up as a ready physical register 0;
- once a squash walk ends, the youngest surviving record is not younger than the squash number;
- once a commit walk ends, the oldest survivor is younger than the commit number.

Only the bench scenarios can show the following:
- the exact order in which freed registers come back out of the FIFO;
- the restored mappings after a multi-record squash;
- the two stall causes and their difference for register 0;
- the treatment of records with equal new and previous registers.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

  typedef enum logic [1:0] {
    HOP_NONE   = 2'd0,
    HOP_PUSH   = 2'd1,
    HOP_UNDO   = 2'd2,
    HOP_RETIRE = 2'd3
  } hop_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rnm_freelist.sv
module rnm_freelist #(
  parameter int unsigned PHYS_REGS = 16,
  parameter int unsigned ARCH_REGS = 8,
  parameter int unsigned PW        = 4,
  localparam int unsigned DEPTH    = PHYS_REGS - ARCH_REGS,
  localparam int unsigned IW       = rnm_pkg::idx_w(DEPTH),
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_phys,
  output logic [PW-1:0] head_phys,
  output logic [CW-1:0] cnt
);

  logic [PW-1:0] mem_q [DEPTH];
  logic [IW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (pop) begin
      head_d = wrap_inc(head_q);
      cnt_d  = cnt_d - 1'b1;
    end
    if (push) begin
      tail_d = wrap_inc(tail_q);
      cnt_d  = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CW'(DEPTH);
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= PW'(ARCH_REGS + i);
    end else if (push) begin
      mem_q[tail_q] <= push_phys;
    end
  end

  assign head_phys = mem_q[head_q];
  assign cnt       = cnt_q;

endmodule

// File: rtl/rnm_history.sv
module rnm_history
  import rnm_pkg::*;
#(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned PW    = 4,
  localparam int unsigned IW   = idx_w(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned EW   = idx_w(2 * DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hop_e             op,
  input  logic [SEQ_W-1:0] in_seq,
  input  logic [AW-1:0]    in_arch,
  input  logic [PW-1:0]    in_new,
  input  logic [PW-1:0]    in_prev,
  output logic [SEQ_W-1:0] old_seq,
  output logic [PW-1:0]    old_new,
  output logic [PW-1:0]    old_prev,
  output logic [SEQ_W-1:0] yng_seq,
  output logic [AW-1:0]    yng_arch,
  output logic [PW-1:0]    yng_new,
  output logic [PW-1:0]    yng_prev,
  output logic [CW-1:0]    cnt
);

  logic [SEQ_W-1:0] seq_q  [DEPTH];
  logic [AW-1:0]    arch_q [DEPTH];
  logic [PW-1:0]    new_q  [DEPTH];
  logic [PW-1:0]    prev_q [DEPTH];

  logic [IW-1:0] head_q, head_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] push_sum, yng_sum;
  logic [IW-1:0] push_idx, yng_idx;

  always_comb begin
    push_sum = EW'(head_q) + EW'(cnt_q);
    yng_sum  = push_sum - 1'b1;
    push_idx = (push_sum >= EW'(DEPTH)) ? IW'(push_sum - EW'(DEPTH)) : IW'(push_sum);
    yng_idx  = (yng_sum  >= EW'(DEPTH)) ? IW'(yng_sum  - EW'(DEPTH)) : IW'(yng_sum);
  end

  always_comb begin
    head_d = head_q;
    cnt_d  = cnt_q;
    unique case (op)
      HOP_PUSH:   cnt_d = cnt_q + 1'b1;
      HOP_UNDO:   cnt_d = cnt_q - 1'b1;
      HOP_RETIRE: begin
        cnt_d  = cnt_q - 1'b1;
        head_d = (head_q == IW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (op == HOP_PUSH) begin
      seq_q[push_idx]  <= in_seq;
      arch_q[push_idx] <= in_arch;
      new_q[push_idx]  <= in_new;
      prev_q[push_idx] <= in_prev;
    end
  end

  assign old_seq  = seq_q[head_q];
  assign old_new  = new_q[head_q];
  assign old_prev = prev_q[head_q];
  assign yng_seq  = seq_q[yng_idx];
  assign yng_arch = arch_q[yng_idx];
  assign yng_new  = new_q[yng_idx];
  assign yng_prev = prev_q[yng_idx];
  assign cnt      = cnt_q;

endmodule

// File: rtl/rnm_maptable.sv
module rnm_maptable #(
  parameter int unsigned ARCH_REGS = 8,
  parameter int unsigned PHYS_REGS = 16,
  parameter int unsigned NUM_SRC   = 2,
  parameter bit          ZERO_REG  = 1'b1,
  parameter int unsigned AW        = 3,
  parameter int unsigned PW        = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC*AW-1:0] src_arch,
  output logic [NUM_SRC*PW-1:0] src_phys,
  output logic [NUM_SRC-1:0]    src_rdy,
  input  logic [AW-1:0]         rd_arch,
  output logic [PW-1:0]         rd_phys,
  input  logic                  map_we,
  input  logic [AW-1:0]         map_arch,
  input  logic [PW-1:0]         map_phys,
  input  logic                  clr_en,
  input  logic [PW-1:0]         clr_phys,
  input  logic                  set_en,
  input  logic [PW-1:0]         set_phys
);

  logic [PW-1:0]        map_q [ARCH_REGS];
  logic [PHYS_REGS-1:0] rdy_q, rdy_d;
  logic                 wr_ok;

  generate
    if (ZERO_REG) begin : g_zero
      assign wr_ok = map_we && (map_arch != '0);
    end else begin : g_nozero
      assign wr_ok = map_we;
    end
  endgenerate

  function automatic logic [PW-1:0] lookup(input logic [AW-1:0] a, input logic [PW-1:0] m);
    return (ZERO_REG && a == '0) ? '0 : m;
  endfunction

  always_comb begin
    rdy_d = rdy_q;
    if (set_en) rdy_d[set_phys] = 1'b1;
    if (clr_en) rdy_d[clr_phys] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= '1;
    else        rdy_q <= rdy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
    end else if (wr_ok) begin
      map_q[map_arch] <= map_phys;
    end
  end

  generate
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_lane
      logic [AW-1:0] a;
      logic [PW-1:0] p;
      assign a = src_arch[k*AW +: AW];
      assign p = lookup(a, map_q[a]);
      assign src_phys[k*PW +: PW] = p;
      assign src_rdy[k] = rdy_q[p];
    end
  endgenerate

  assign rd_phys = lookup(rd_arch, map_q[rd_arch]);

endmodule

// File: rtl/rename_map_hist.sv
module rename_map_hist
  import rnm_pkg::*;
#(
  parameter int unsigned ARCH_REGS  = 8,
  parameter int unsigned PHYS_REGS  = 16,
  parameter int unsigned HIST_DEPTH = 12,
  parameter int unsigned NUM_SRC    = 2,
  parameter int unsigned SEQ_W      = 8,
  parameter bit          ZERO_REG   = 1'b1,
  localparam int unsigned AW        = idx_w(ARCH_REGS),
  localparam int unsigned PW        = idx_w(PHYS_REGS),
  localparam int unsigned FL_DEPTH  = PHYS_REGS - ARCH_REGS,
  localparam int unsigned FCW       = $clog2(FL_DEPTH + 1),
  localparam int unsigned HCW       = $clog2(HIST_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC*AW-1:0] src_arch,
  output logic [NUM_SRC*PW-1:0] src_phys,
  output logic [NUM_SRC-1:0]    src_rdy,
  input  logic                  ren_valid,
  input  logic [AW-1:0]         ren_arch,
  input  logic [SEQ_W-1:0]      ren_seq,
  output logic                  ren_ready,
  output logic [PW-1:0]         ren_phys,
  output logic [PW-1:0]         ren_prev,
  input  logic                  wb_valid,
  input  logic [PW-1:0]         wb_phys,
  input  logic                  cmt_valid,
  input  logic [SEQ_W-1:0]      cmt_seq,
  input  logic                  sq_valid,
  input  logic [SEQ_W-1:0]      sq_seq
);

  // walk control state
  logic             sq_act_q, sq_act_d;
  logic [SEQ_W-1:0] sq_tgt_q, sq_tgt_d;
  logic             cmt_act_q, cmt_act_d;
  logic [SEQ_W-1:0] cmt_tgt_q, cmt_tgt_d;

  // history outputs
  logic [SEQ_W-1:0] old_seq, yng_seq;
  logic [PW-1:0]    old_new, old_prev, yng_new, yng_prev;
  logic [AW-1:0]    yng_arch;
  logic [HCW-1:0]   hist_cnt;
  hop_e             hop;

  // free list
  logic [PW-1:0]  fl_head;
  logic [FCW-1:0] free_cnt;
  logic           fl_pop, fl_push;
  logic [PW-1:0]  fl_push_phys;

  // map write
  logic          map_we;
  logic [AW-1:0] map_arch;
  logic [PW-1:0] map_phys;

  logic zero_dst, hist_full, fire, undo, retire, undo_frees, retire_frees;

  assign zero_dst  = ZERO_REG && (ren_arch == '0);
  assign hist_full = (hist_cnt == HCW'(HIST_DEPTH));

  assign ren_ready = !sq_valid && !sq_act_q && !cmt_valid && !cmt_act_q &&
                     !hist_full && (zero_dst || free_cnt != '0);
  assign fire      = ren_valid && ren_ready;

  assign undo   = sq_act_q && (hist_cnt != '0) && (yng_seq > sq_tgt_q);
  assign retire = !sq_act_q && cmt_act_q && (hist_cnt != '0) && (old_seq <= cmt_tgt_q);

  assign undo_frees   = undo   && (yng_new != yng_prev);
  assign retire_frees = retire && (old_new != old_prev);

  always_comb begin
    sq_act_d  = sq_act_q;
    sq_tgt_d  = sq_tgt_q;
    cmt_act_d = cmt_act_q;
    cmt_tgt_d = cmt_tgt_q;
    if (sq_valid) begin
      sq_act_d = 1'b1;
      sq_tgt_d = sq_seq;
    end else if (sq_act_q && !undo) begin
      sq_act_d = 1'b0;
    end
    if (cmt_valid) begin
      cmt_act_d = 1'b1;
      cmt_tgt_d = cmt_seq;
    end else if (cmt_act_q && !sq_act_q && !retire) begin
      cmt_act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_act_q  <= 1'b0;
      sq_tgt_q  <= '0;
      cmt_act_q <= 1'b0;
      cmt_tgt_q <= '0;
    end else begin
      sq_act_q  <= sq_act_d;
      sq_tgt_q  <= sq_tgt_d;
      cmt_act_q <= cmt_act_d;
      cmt_tgt_q <= cmt_tgt_d;
    end
  end

  always_comb begin
    hop          = HOP_NONE;
    fl_push      = 1'b0;
    fl_push_phys = '0;
    map_we       = 1'b0;
    map_arch     = ren_arch;
    map_phys     = fl_head;
    if (undo) begin
      hop          = HOP_UNDO;
      fl_push      = undo_frees;
      fl_push_phys = yng_new;
      map_we       = undo_frees;
      map_arch     = yng_arch;
      map_phys     = yng_prev;
    end else if (retire) begin
      hop          = HOP_RETIRE;
      fl_push      = retire_frees;
      fl_push_phys = old_prev;
    end else if (fire) begin
      hop    = HOP_PUSH;
      map_we = !zero_dst;
    end
  end

  assign fl_pop   = fire && !zero_dst;
  assign ren_phys = zero_dst ? '0 : fl_head;

  rnm_freelist #(
    .PHYS_REGS(PHYS_REGS), .ARCH_REGS(ARCH_REGS), .PW(PW)
  ) u_free (
    .clk(clk), .rst_n(rst_n), .pop(fl_pop), .push(fl_push),
    .push_phys(fl_push_phys), .head_phys(fl_head), .cnt(free_cnt)
  );

  rnm_history #(
    .DEPTH(HIST_DEPTH), .SEQ_W(SEQ_W), .AW(AW), .PW(PW)
  ) u_hist (
    .clk(clk), .rst_n(rst_n), .op(hop),
    .in_seq(ren_seq), .in_arch(ren_arch), .in_new(ren_phys), .in_prev(ren_prev),
    .old_seq(old_seq), .old_new(old_new), .old_prev(old_prev),
    .yng_seq(yng_seq), .yng_arch(yng_arch), .yng_new(yng_new), .yng_prev(yng_prev),
    .cnt(hist_cnt)
  );

  rnm_maptable #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .NUM_SRC(NUM_SRC),
    .ZERO_REG(ZERO_REG), .AW(AW), .PW(PW)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .src_arch(src_arch), .src_phys(src_phys), .src_rdy(src_rdy),
    .rd_arch(ren_arch), .rd_phys(ren_prev),
    .map_we(map_we), .map_arch(map_arch), .map_phys(map_phys),
    .clr_en(fl_pop), .clr_phys(fl_head),
    .set_en(wb_valid), .set_phys(wb_phys)
  );

endmodule

// File: rtl/rnm_checker.sv
module rnm_checker #(
  parameter int unsigned AW         = 3,
  parameter int unsigned PW         = 4,
  parameter int unsigned SEQ_W      = 8,
  parameter int unsigned HCW        = 4,
  parameter int unsigned FCW        = 4,
  parameter int unsigned HIST_DEPTH = 12,
  parameter int unsigned FL_DEPTH   = 8,
  parameter bit          ZERO_REG   = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sq_valid,
  input logic             sq_act,
  input logic             cmt_valid,
  input logic             cmt_act,
  input logic             ren_ready,
  input logic [HCW-1:0]   hist_cnt,
  input logic [FCW-1:0]   free_cnt,
  input logic [SEQ_W-1:0] yng_seq,
  input logic [SEQ_W-1:0] old_seq,
  input logic [SEQ_W-1:0] sq_tgt,
  input logic [SEQ_W-1:0] cmt_tgt,
  input logic [AW-1:0]    lane0_arch,
  input logic [PW-1:0]    lane0_phys,
  input logic             lane0_rdy
);

  assert_recovery_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid || sq_act || cmt_valid || cmt_act) |-> !ren_ready);

  assert_one_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hist_cnt == $past(hist_cnt) || hist_cnt == $past(hist_cnt) + 1'b1 ||
              hist_cnt + 1'b1 == $past(hist_cnt)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hist_cnt <= HCW'(HIST_DEPTH) && free_cnt <= FCW'(FL_DEPTH));

  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ZERO_REG && lane0_arch == '0) |-> (lane0_phys == '0 && lane0_rdy));

  assert_squash_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sq_act) |-> (hist_cnt == '0 || yng_seq <= $past(sq_tgt)));

  assert_commit_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmt_act) |-> (hist_cnt == '0 || old_seq > $past(cmt_tgt)));

endmodule

bind rename_map_hist rnm_checker #(
  .AW(AW), .PW(PW), .SEQ_W(SEQ_W), .HCW(HCW), .FCW(FCW),
  .HIST_DEPTH(HIST_DEPTH), .FL_DEPTH(FL_DEPTH), .ZERO_REG(ZERO_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .sq_act(sq_act_q),
  .cmt_valid(cmt_valid), .cmt_act(cmt_act_q), .ren_ready(ren_ready),
  .hist_cnt(hist_cnt), .free_cnt(free_cnt), .yng_seq(yng_seq), .old_seq(old_seq),
  .sq_tgt(sq_tgt_q), .cmt_tgt(cmt_tgt_q),
  .lane0_arch(src_arch[AW-1:0]), .lane0_phys(src_phys[PW-1:0]), .lane0_rdy(src_rdy[0])
);

// File: tb/sim_rename_map_hist.sv
`timescale 1ns/1ps
module sim_rename_map_hist;

  localparam int AW = 3;
  localparam int PW = 4;
  localparam int SW = 8;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS*AW-1:0] src_arch = '0;
  logic [NS*PW-1:0] src_phys;
  logic [NS-1:0]    src_rdy;
  logic             ren_valid = 1'b0;
  logic [AW-1:0]    ren_arch = '0;
  logic [SW-1:0]    ren_seq = '0;
  logic             ren_ready;
  logic [PW-1:0]    ren_phys, ren_prev;
  logic             wb_valid = 1'b0;
  logic [PW-1:0]    wb_phys = '0;
  logic             cmt_valid = 1'b0;
  logic [SW-1:0]    cmt_seq = '0;
  logic             sq_valid = 1'b0;
  logic [SW-1:0]    sq_seq = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rename_map_hist u0 (
    .clk(clk), .rst_n(rst_n), .src_arch(src_arch), .src_phys(src_phys), .src_rdy(src_rdy),
    .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_seq(ren_seq), .ren_ready(ren_ready),
    .ren_phys(ren_phys), .ren_prev(ren_prev), .wb_valid(wb_valid), .wb_phys(wb_phys),
    .cmt_valid(cmt_valid), .cmt_seq(cmt_seq), .sq_valid(sq_valid), .sq_seq(sq_seq)
  );

  // stimulus table: arch, seq, expected new phys, expected previous phys
  localparam int VEC [5][4] = '{
    '{1, 1,  8, 1},
    '{2, 2,  9, 2},
    '{1, 3, 10, 8},
    '{0, 4,  0, 0},
    '{3, 5, 11, 3}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ren(input int arch, input int seq, input int ep, input int epr, input string req);
    @(negedge clk);
    ren_valid = 1'b1; ren_arch = AW'(arch); ren_seq = SW'(seq);
    #1;
    check({req, " ready"}, int'(ren_ready), 1);
    check({req, " new phys"}, int'(ren_phys), ep);
    if (epr >= 0) check({req, " prev phys"}, int'(ren_prev), epr);
    @(posedge clk); #1;
    ren_valid = 1'b0;
  endtask

  task automatic look(input int arch, input int ep, input int erdy, input string req);
    @(negedge clk);
    src_arch[AW-1:0] = AW'(arch);
    #1;
    check({req, " lookup phys"}, int'(src_phys[PW-1:0]), ep);
    check({req, " lookup rdy"}, int'(src_rdy[0]), erdy);
  endtask

  task automatic wait_idle(input string req);
    bit done = 1'b0;
    ren_arch = '0;
    for (int k = 0; k < 40 && !done; k++) begin
      @(negedge clk); #1;
      if (ren_ready) done = 1'b1;
    end
    check({req, " walk finished"}, int'(done), 1);
  endtask

  task automatic do_squash(input int seq);
    @(negedge clk);
    ren_arch = '0; sq_valid = 1'b1; sq_seq = SW'(seq);
    #1 check("R9 ren blocked by squash request", int'(ren_ready), 0);
    @(posedge clk); #1 sq_valid = 1'b0;
    @(negedge clk); #1 check("R9 ren blocked during squash walk", int'(ren_ready), 0);
    wait_idle("R5");
  endtask

  task automatic do_commit(input int seq);
    @(negedge clk);
    ren_arch = '0; cmt_valid = 1'b1; cmt_seq = SW'(seq);
    #1 check("R9 ren blocked by commit request", int'(ren_ready), 0);
    @(posedge clk); #1 cmt_valid = 1'b0;
    wait_idle("R6");
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state, R8 register zero
    look(3, 3, 1, "R1");
    look(0, 0, 1, "R8");
    @(negedge clk); src_arch[2*AW-1:AW] = 3'd7; #1;
    check("R1 lane1 phys", int'(src_phys[2*PW-1:PW]), 7);

    // table walk: R1 FIFO order, R2 prev, R8 zero rename
    for (int i = 0; i < 5; i++)
      ren(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], "R2");

    look(1, 10, 0, "R2");
    look(2, 9, 0, "R2");

    // R3 writeback
    @(negedge clk); wb_valid = 1'b1; wb_phys = 4'd10;
    @(posedge clk); #1 wb_valid = 1'b0;
    look(1, 10, 1, "R3");

    // R5 squash after 2 (R10: seq 2 kept)
    do_squash(2);
    look(1, 8, 0, "R5");
    look(3, 3, 1, "R5");
    look(2, 9, 0, "R10");
    ren(4, 10, 12, 4, "R5 fifo order");

    // R6 commit 2, R10 equal seq removed; commit 5 removes nothing
    do_commit(2);
    do_commit(5);
    do_squash(9);
    look(4, 4, 1, "R6 young record kept by commit");

    // R7 / R8 zero record commit frees nothing
    ren(0, 20, 0, 0, "R8");
    do_commit(20);

    // fill the free list: expected order 13,14,15,11,10,1,2,12
    begin
      int ep [8] = '{13, 14, 15, 11, 10, 1, 2, 12};
      int epr[8] = '{8, 9, 3, 4, 5, 6, 7, 13};
      for (int i = 0; i < 8; i++)
        ren((i % 7) + 1, 30 + i, ep[i], epr[i], "R6 R7 release order");
    end

    // R4 free list empty
    @(negedge clk); ren_valid = 1'b1; ren_arch = 3'd5; #1;
    check("R4 stall on empty free list", int'(ren_ready), 0);
    ren_arch = 3'd0; #1;
    check("R8 zero dest accepted with empty free list", int'(ren_ready), 1);
    ren_valid = 1'b0;
    for (int i = 0; i < 4; i++) ren(0, 40 + i, 0, 0, "R8");
    @(negedge clk); ren_valid = 1'b1; ren_arch = 3'd0; #1;
    check("R4 stall on full history", int'(ren_ready), 0);
    ren_valid = 1'b0;

    // R5 deep squash, youngest first
    do_squash(29);
    look(1, 8, 0, "R5");
    look(5, 5, 1, "R5");
    look(7, 7, 1, "R5");
    ren(3, 50, 12, 3, "R5 youngest freed first");
    ren(3, 51, 2, 12, "R5 second youngest");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule